// File: doc/BRIEF.md
# Cascaded Two-Bank Vectored Interrupt Arbiter

This block merges two interrupt banks into one arbiter for 64 level-sensitive request lines. Request bit i of bank 0 is source i. Request bit i of bank 1 is source 32+i. Each bank holds a set of vector slots. Software writes into each slot a 5-bit source index and an enable bit. A source named by an enabled slot is a vectored source. Every other source is unvectored.

Each cycle the block picks one winner among the active, unmasked requests. It searches in this order:
1. the vectored sources of bank 0,
2. the vectored sources of bank 1,
3. the unvectored sources of bank 0,
4. the unvectored sources of bank 1.

The result is stored in one shared 11-bit vector code, so a single read is enough to identify the overall winner. A combined interrupt output goes high whenever any enabled request is pending.

Software reaches the masks, the status words, the slots and the vector code through a plain register port. Writes take effect on the clock edge. Reads are combinational from the address. The 8-bit address map is:
- Bank base: 0x00 for bank 0 and 0x40 for bank 1.
- Mask: at offset 0x00 from the bank base.
- Raw status: at offset 0x01.
- Masked status: at offset 0x02.
- Slot s: at offset 0x20+s.
- Vector code: at 0x80.

Top module: `cascade_irq_vector`

## Requirements
- R1: Bank 1 request bit i is source 32+i. A vectored winner produces the code 0x100 | source, with the source number in bits 5:0. Source 0 therefore reads 0x100.
- R2: An active request named by an enabled slot always beats every active request that is not named by an enabled slot, in either bank.
- R3: The search order is: vectored sources of bank 0, then vectored sources of bank 1, then unvectored sources of bank 0, then unvectored sources of bank 1.
- R4: Among the enabled slots of one bank that hit, the lowest slot index wins. A disabled slot has no effect on arbitration.
- R5: When the winner is an unvectored bank 0 source, the code is exactly 0x200, with bits 7:0 zero.
- R6: When the winner is an unvectored bank 1 source, the code is exactly 0x400.
- R7: When no enabled request is active, the code is 0x000 and irq_o is low.
- R8: A request whose mask bit is 0 has no effect on the code, on irq_o or on the masked status.
- R9: irq_o is high exactly when some request is both active and unmasked. It changes in the same cycle as the code.
- R10: The code and irq_o are registered. They reflect requests, masks and slots as sampled at the previous rising clock edge.
- R11: Register map and field layout:
  - Mask (bank offset 0x00) is read/write.
  - Raw status (offset 0x01) reads req_i and ignores writes.
  - Masked status (offset 0x02) reads req_i AND mask.
  - Slot s (offset 0x20+s) holds the source in bits 4:0 and the enable in bit 7.
  - Address 0x80 reads the code.
  - Unmapped addresses read 0.
- R12: After reset, both masks are 0, every slot reads 0 (disabled), the code is 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 64 | Level requests. Bits 31:0 go to bank 0, bits 63:32 to bank 1 |
| addr_i | input | 8 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| vect_o | output | 11 | Registered vector code |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that req_i, addr_i and the write port are synchronous to clk_i and stable around the rising edge. Under that assumption the registered code can be related to the pending and hit state of the previous edge. The raw-status read can also be compared with req_i in the same sample. The bench respects this by changing every input only on the falling edge. It then samples results one full rising edge after the last stimulus change, so the code and irq_o have always seen settled inputs.

// File: rtl/cvic_pkg.sv
package cvic_pkg;
  localparam int unsigned LINES    = 32;
  localparam int unsigned SRC_W    = 5;
  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned VEC_W    = 11;
  localparam int unsigned SLOT_EN_BIT = 7;
  localparam logic [VEC_W-1:0] CODE_U0 = 11'h200;
  localparam logic [VEC_W-1:0] CODE_U1 = 11'h400;

  typedef struct packed {
    logic             en;
    logic [SRC_W-1:0] src;
  } slot_cfg_t;

  function automatic logic [VEC_W-1:0] vec_code(input logic [SRC_W:0] id);
    return {3'b001, 2'b00, id};
  endfunction
endpackage

// File: rtl/cvic_pick.sv
module cvic_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cvic_bank.sv
module cvic_bank
  import cvic_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic             we_i,
  input  logic [5:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             vec_hit_o,
  output logic [SRC_W-1:0] vec_src_o,
  output logic             pend_o
);
  logic [LINES-1:0]     mask_q;
  slot_cfg_t            slot_q [NUM_SLOTS];
  logic [LINES-1:0]     masked;
  logic [NUM_SLOTS-1:0] hit;
  logic [IDX_W-1:0]     win_idx;

  assign masked = req_i & mask_q;
  assign pend_o = |masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
    end else if (we_i) begin
      if (addr_i == 6'd0) mask_q <= wdata_i;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (addr_i == 6'(32 + s))
          slot_q[s] <= '{en: wdata_i[SLOT_EN_BIT], src: wdata_i[SRC_W-1:0]};
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = slot_q[s].en & masked[slot_q[s].src];
  end

  cvic_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) i_pick (
    .hit_i (hit),
    .any_o (vec_hit_o),
    .idx_o (win_idx)
  );

  assign vec_src_o = slot_q[win_idx].src;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      6'd0: rdata_o = mask_q;
      6'd1: rdata_o = req_i;
      6'd2: rdata_o = masked;
      default: begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (addr_i == 6'(32 + s))
            rdata_o = 32'({slot_q[s].en, 2'b00, slot_q[s].src});
        end
      end
    endcase
  end
endmodule

// File: rtl/cascade_irq_vector.sv
module cascade_irq_vector
  import cvic_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BANK*LINES-1:0] req_i,
  input  logic [7:0]                addr_i,
  input  logic                      we_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [VEC_W-1:0]          vect_o,
  output logic                      irq_o
);
  logic [NUM_BANK-1:0] pend;
  logic [NUM_BANK-1:0] hit;
  logic [SRC_W-1:0]    src  [NUM_BANK];
  logic [31:0]         bank_rd [NUM_BANK];
  logic [VEC_W-1:0]    vect_d;

  for (genvar c = 0; c < NUM_BANK; c++) begin : g_bank
    cvic_bank #(.NUM_SLOTS(NUM_SLOTS)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[c*LINES +: LINES]),
      .we_i      (we_i && !addr_i[7] && (addr_i[6] == 1'(c))),
      .addr_i    (addr_i[5:0]),
      .wdata_i   (wdata_i),
      .rdata_o   (bank_rd[c]),
      .vec_hit_o (hit[c]),
      .vec_src_o (src[c]),
      .pend_o    (pend[c])
    );
  end

  // global order: vec bank0, vec bank1, unvec bank0, unvec bank1
  always_comb begin
    if (hit[0])       vect_d = vec_code({1'b0, src[0]});
    else if (hit[1])  vect_d = vec_code({1'b1, src[1]});
    else if (pend[0]) vect_d = CODE_U0;
    else if (pend[1]) vect_d = CODE_U1;
    else              vect_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vect_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      vect_o <= vect_d;
      irq_o  <= |pend;
    end
  end

  always_comb begin
    if (addr_i[7]) rdata_o = (addr_i[6:0] == 7'd0) ? 32'(vect_o) : '0;
    else           rdata_o = bank_rd[addr_i[6]];
  end
endmodule

// File: rtl/cvic_chk.sv
module cvic_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] req_i,
  input logic [7:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic [10:0] vect_o,
  input logic        irq_o,
  input logic [1:0]  pend_i,
  input logic [1:0]  hit_i
);
  // R9
  irq_follows_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|pend_i));
  // R2
  vec_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> vect_o[8]);
  // R3
  unvec_b1_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vect_o[10] |-> ($past(hit_i) == 2'b00 && !$past(pend_i[0])));
  // R5
  flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vect_o[10:8]));
  // R5
  unvec_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vect_o[9] || vect_o[10]) |-> vect_o[7:0] == 8'h00);
  // R7
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vect_o == 11'h000);
  // R11
  raw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h41) |-> rdata_o == req_i[63:32]);
  // R11
  vect_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h80) |-> rdata_o == 32'(vect_o));
endmodule

bind cascade_irq_vector cvic_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .vect_o  (vect_o),
  .irq_o   (irq_o),
  .pend_i  (pend),
  .hit_i   (hit)
);

// File: tb/test_cascade_irq_vector.sv
module test_cascade_irq_vector;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] req_i = '0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [10:0] vect_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_mask [2];
  logic [4:0]  m_src  [2][16];
  logic        m_en   [2][16];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk_i = ~clk_i;

  cascade_irq_vector i_cascade_irq_vector (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .vect_o(vect_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [10:0] model(input logic [63:0] r);
    logic [63:0] m;
    m = r & {m_mask[1], m_mask[0]};
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 16; s++)
        if (m_en[c][s] && m[c*32 + int'(m_src[c][s])])
          return 11'h100 | 11'(c*32 + int'(m_src[c][s]));
    if (|m[31:0])  return 11'h200;
    if (|m[63:32]) return 11'h400;
    return 11'h000;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic set_mask(input int c, input logic [31:0] v);
    wr(8'(c*64), v);
    m_mask[c] = v;
  endtask

  task automatic set_slot(input int c, input int s, input logic en, input logic [4:0] src);
    wr(8'(c*64 + 32 + s), {24'b0, en, 2'b00, src});
    m_en[c][s] = en;
    m_src[c][s] = src;
  endtask

  // apply request, wait one rising edge, then compare
  task automatic apply(input string tag, input logic [63:0] r);
    logic [10:0] e;
    @(negedge clk_i);
    req_i = r;
    @(negedge clk_i);
    e = model(r);
    check(tag, 32'(vect_o), 32'(e));
    check({tag, " irq"}, 32'(irq_o), 32'(e != 0));
  endtask

  function automatic logic [63:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      m_mask[c] = '0;
      for (int s = 0; s < 16; s++) begin m_en[c][s] = 1'b0; m_src[c][s] = '0; end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check("R12 vect", 32'(vect_o), 32'h0);
    check("R12 irq", 32'(irq_o), 32'h0);
    rd(8'h00, d); check("R12 mask0", d, 32'h0);
    rd(8'h40, d); check("R12 mask1", d, 32'h0);
    rd(8'h2F, d); check("R12 slot0_15", d, 32'h0);
    rd(8'h60, d); check("R12 slot1_0", d, 32'h0);

    // R7 nothing enabled while requests active (masks 0), R8
    apply("R8 all masked", 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h02, d); check("R8 masked status0", d, 32'h0);
    apply("R7 idle", 64'h0);

    set_mask(0, 32'hFFFF_FFFF);
    set_mask(1, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R11 mask1 readback", d, 32'hFFFF_FFFF);

    // R5 R6 unvectored single-source sweep
    for (int i = 0; i < 64; i++)
      apply(i < 32 ? "R5 unvec bank0" : "R6 unvec bank1", 64'd1 << i);
    apply("R3 bank0 unvec over bank1 unvec", (64'd1 << 40) | (64'd1 << 31));

    // R8 per-bit mask sweep
    set_mask(0, 32'h0);
    for (int i = 0; i < 32; i++) apply("R8 masked bit", 64'd1 << i);
    set_mask(0, 32'hFFFF_FFFF);

    // program slots
    for (int s = 0; s < 16; s++) begin
      set_slot(0, s, s != 5, 5'((s*7 + 3) % 32));
      set_slot(1, s, (s % 4) != 3, 5'((s*5 + 1) % 32));
    end
    set_slot(0, 15, 1'b1, 5'd0);
    rd(8'h21, d); check("R11 slot0_1 layout", d, 32'h0000_008A);
    rd(8'h25, d); check("R11 slot0_5 disabled", d, 32'h0000_0006);
    rd(8'h63, d); check("R11 slot1_3 disabled", d, 32'h0000_0010);

    // R1 R4 single-source sweep with slots
    for (int i = 0; i < 64; i++) apply("R1 single source", 64'd1 << i);
    apply("R1 source0 vectored", 64'd1);
    check("R1 source0 code", 32'(vect_o), 32'h100);
    apply("R4 lowest slot wins", (64'd1 << 3) | (64'd1 << 10));
    check("R4 slot0 code", 32'(vect_o), 32'h103);
    apply("R4 disabled slot ignored", 64'd1 << 6);
    check("R4 disabled code", 32'(vect_o), 32'h200);
    apply("R3 bank1 vec over bank0 unvec", (64'd1 << 6) | (64'd1 << 33));
    check("R3 cross code", 32'(vect_o), 32'h121);
    apply("R2 vec over all unvec", 64'hFFFF_FFFF_0000_0040 | (64'd1 << 33));
    check("R2 code", 32'(vect_o), 32'h121);

    // R2 R3 R4 random patterns, full masks
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r;
      r = next_rand();
      if (k % 3 == 1) r = r & next_rand() & next_rand();
      if (k % 3 == 2) r = r & next_rand() & next_rand() & next_rand() & next_rand();
      apply("R3 random order", r);
    end
    // R8 random masks
    for (int k = 0; k < 60; k++) begin
      logic [63:0] mr;
      mr = next_rand();
      set_mask(0, mr[31:0]);
      set_mask(1, mr[63:32]);
      apply("R8 random mask", next_rand() & next_rand());
    end

    // R11 status reads, write to raw ignored
    set_mask(0, 32'h0F0F_00FF);
    @(negedge clk_i); req_i = 64'h1234_5678_9ABC_DEF0;
    rd(8'h01, d); check("R11 raw0", d, 32'h9ABC_DEF0);
    rd(8'h41, d); check("R11 raw1", d, 32'h1234_5678);
    rd(8'h02, d); check("R11 masked0", d, 32'h0A0C_00F0);
    wr(8'h01, 32'hFFFF_FFFF);
    @(negedge clk_i); req_i = '0;
    rd(8'h01, d); check("R11 raw write ignored", d, 32'h0);
    rd(8'h03, d); check("R11 unmapped", d, 32'h0);
    apply("R11 vect setup", 64'd1 << 33);
    rd(8'h80, d); check("R11 vect read", d, 32'h121);

    // R10 registered timing
    @(negedge clk_i); req_i = 64'd1 << 3;
    #1 check("R10 before edge", 32'(vect_o), 32'h121);
    @(negedge clk_i);
    check("R10 after edge", 32'(vect_o), 32'h103);
    @(negedge clk_i); addr_i = 8'h00; wdata_i = 32'h0; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; m_mask[0] = 32'h0;
    #1 check("R10 mask write lag", 32'(irq_o), 32'h1);
    @(negedge clk_i);
    check("R9 irq drops", 32'(irq_o), 32'h0);
    check("R7 code after mask", 32'(vect_o), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule